// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 16-bit wide asynchronous static RAM inside a synchronous design. A fast internal clock samples the memory-side control pins. These are two chip enables of opposite polarity, a write enable, an output enable and one select per byte lane. From the sampled pins the block decodes one of four modes: deselected, output disabled, read or write. It keeps a word array that it updates one byte lane at a time. The data bus is split into an input vector, an output vector and one output-enable bit per lane, so a pad ring or a testbench can model the tri-state bus outside the block.

The block follows pin-level signalling, not a stream, so there is no valid/ready handshake. Every input is a plain level. Every input passes one sampling register, and the lane enables, read data and standby flag leave from a second register. A pin change therefore shows at the outputs two clock edges after it is sampled. A write is committed once, when the sampled write overlap ends. It uses the address, data and lane mask from the last sample inside the overlap. The default address width is kept small for elaboration; a 128K-word part uses `ADDR_W = 17`.

Top module: `sram_pin_emu`

## Requirements
- R1: The array holds 2**ADDR_W words of 16 bits, and every word is written and read back independently of every other word.
- R2: When `ce_lo_n` is 1, or `ce_hi` is 0, or both bits of `lane_sel_n` are 1, the block is deselected: `bus_oe` is 00 and `standby` is 1. In every other case `standby` is 0.
- R3: When the block is selected with `wr_n` = 1 and `rd_en_n` = 1, `bus_oe` is 00.
- R4: When the block is selected with `wr_n` = 1 and `rd_en_n` = 0, lane 0 (bits 7:0, selected by `lane_sel_n[0]` = 0) and lane 1 (bits 15:8, selected by `lane_sel_n[1]` = 0) each drive the stored byte of `addr` when selected and are not enabled otherwise.
- R5: When the block is selected with `wr_n` = 0, each lane whose select is 0 stores its byte of `bus_in` whatever the level of `rd_en_n`; a lane whose select is 1 keeps its old byte.
- R6: While the sampled `wr_n` is 0, `bus_oe` is 00.
- R7: A write stores the data present in the last sample before the overlap of selection and `wr_n` = 0 ends, and it is committed exactly once per overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| ce_lo_n | input | 1 | Active-low chip enable |
| ce_hi | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low output enable |
| lane_sel_n | input | 2 | Active-low byte-lane selects, bit 0 for bits 7:0 |
| bus_in | input | 16 | Data arriving on the bus |
| bus_out | output | 16 | Data the block would drive |
| bus_oe | output | 2 | Per-lane drive enable, bit 0 for bits 7:0 |
| standby | output | 1 | High while the block is deselected |

## Verification
The bench first fills every word with a value computed from its address. It then steps through all 64 combinations of the two enables, write enable, output enable and the two lane selects, each at its own address with its own data. This separates the three ways of deselecting the block from output disable, and shows that a write ignores the output enable. It also separates single-lane reads and writes from word accesses and lets the other lane's byte be checked after a one-lane write. A final read of every word catches a write that landed on the wrong word or lane. One long write, with its data changed part way through, shows that only the last value is kept.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ODIS  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mode_e;
endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_lo_n,
  input  logic              ce_hi,
  input  logic              wr_n,
  input  logic              rd_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [DATA_W-1:0] bus_in,
  output mode_e             s_mode,
  output logic [ADDR_W-1:0] s_addr,
  output logic [LANES-1:0]  s_sel_n,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data,
  output logic [LANES-1:0]  c_mask
);
  logic              s_ce_lo_n, s_ce_hi, s_wr_n, s_rd_en_n;
  logic [DATA_W-1:0] s_data;
  logic              p_ov;
  logic              ov;

  // first register: raw pin samples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ce_lo_n <= 1'b1;
      s_ce_hi   <= 1'b0;
      s_wr_n    <= 1'b1;
      s_rd_en_n <= 1'b1;
      s_sel_n   <= '1;
      s_addr    <= '0;
      s_data    <= '0;
    end else begin
      s_ce_lo_n <= ce_lo_n;
      s_ce_hi   <= ce_hi;
      s_wr_n    <= wr_n;
      s_rd_en_n <= rd_en_n;
      s_sel_n   <= lane_sel_n;
      s_addr    <= addr;
      s_data    <= bus_in;
    end
  end

  always_comb begin
    if (s_ce_lo_n || !s_ce_hi || (&s_sel_n)) s_mode = MODE_OFF;
    else if (!s_wr_n)                        s_mode = MODE_WRITE;
    else if (s_rd_en_n)                      s_mode = MODE_ODIS;
    else                                     s_mode = MODE_READ;
  end

  assign ov = (s_mode == MODE_WRITE);

  // previous sample, used when the overlap closes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_ov   <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
      c_mask <= '0;
    end else begin
      p_ov   <= ov;
      c_addr <= s_addr;
      c_data <= s_data;
      c_mask <= ~s_sel_n;
    end
  end

  assign commit = p_ov && !ov;

  // R7: one commit per overlap, never on two consecutive samples
  p_single_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wmask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && wmask[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
      rd_q <= bank[raddr];
    end
    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_lane_drive.sv
module sram_lane_drive
  import sram_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_e            s_mode,
  input  logic [LANES-1:0] s_sel_n,
  output logic [LANES-1:0] bus_oe,
  output logic             standby
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_oe  <= '0;
      standby <= 1'b1;
    end else begin
      bus_oe  <= (s_mode == MODE_READ) ? ~s_sel_n : '0;
      standby <= (s_mode == MODE_OFF);
    end
  end

  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode == MODE_OFF) |=> (standby && bus_oe == '0));
  p_odis_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode == MODE_ODIS) |=> (bus_oe == '0 && !standby));
  p_read_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode == MODE_READ) |=> (bus_oe == ~$past(s_sel_n)));
  p_no_drive_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode == MODE_WRITE) |=> (bus_oe == '0));
endmodule

// File: rtl/sram_pin_emu.sv
module sram_pin_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_lo_n,
  input  logic              ce_hi,
  input  logic              wr_n,
  input  logic              rd_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [LANES-1:0]  bus_oe,
  output logic              standby
);
  mode_e             s_mode;
  logic [ADDR_W-1:0] s_addr, c_addr;
  logic [LANES-1:0]  s_sel_n, c_mask;
  logic [DATA_W-1:0] c_data;
  logic              commit;

  sram_pin_sampler #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sample (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
    .wr_n(wr_n), .rd_en_n(rd_en_n), .lane_sel_n(lane_sel_n), .bus_in(bus_in),
    .s_mode(s_mode), .s_addr(s_addr), .s_sel_n(s_sel_n), .commit(commit),
    .c_addr(c_addr), .c_data(c_data), .c_mask(c_mask)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(commit), .waddr(c_addr), .wdata(c_data), .wmask(c_mask),
    .raddr(s_addr), .rdata(bus_out)
  );

  sram_lane_drive #(.LANES(LANES)) u_drive (
    .clk(clk), .rst_n(rst_n), .s_mode(s_mode), .s_sel_n(s_sel_n),
    .bus_oe(bus_oe), .standby(standby)
  );

  // R5/R7: a commit always carries at least one lane
  p_commit_has_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (c_mask != '0));
endmodule

// File: tb/test_sram_pin_emu.sv
module test_sram_pin_emu;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_lo_n = 1'b1, ce_hi = 1'b0, wr_n = 1'b1, rd_en_n = 1'b1;
  logic [1:0]    lane_sel_n = 2'b11;
  logic [15:0]   bus_in = '0;
  logic [15:0]   bus_out;
  logic [1:0]    bus_oe;
  logic          standby;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [15:0] ref_mem [NW];

  always #5 clk = ~clk;

  sram_pin_emu #(.ADDR_W(AW)) i_sram_pin_emu (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
    .wr_n(wr_n), .rd_en_n(rd_en_n), .lane_sel_n(lane_sel_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .standby(standby)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c1n, input logic c2, input logic oen, input logic wen,
                       input logic [1:0] bs, input logic [AW-1:0] a, input logic [15:0] d);
    ce_lo_n = c1n; ce_hi = c2; rd_en_n = oen; wr_n = wen;
    lane_sel_n = bs; addr = a; bus_in = d;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle(input logic [AW-1:0] a);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, a, 16'h0000);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input string req);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, a, 16'h0000);
    chk(req, {14'd0, bus_oe}, 16'h0003);
    chk(req, bus_out, ref_mem[a]);
    go_idle(a);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset standby", {15'd0, standby}, 16'h0001);
    chk("R2 reset oe", {14'd0, bus_oe}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: fill every word
    for (int a = 0; a < NW; a++) begin
      logic [15:0] v;
      v = 16'(a * 16'h03B1 + 16'h1234);
      drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, AW'(a), v);
      go_idle(AW'(a));
      ref_mem[a] = v;
    end

    // all 64 pin combinations, one per address
    for (int i = 0; i < 64; i++) begin
      logic c1n, c2, oen, wen, sel;
      logic [1:0] bs, exp_oe;
      logic [15:0] d, m;
      c1n = i[5]; c2 = i[4]; oen = i[3]; wen = i[2]; bs = i[1:0];
      d = 16'(i * 16'h0123) ^ 16'hA55A;
      sel = !c1n && c2 && !(&bs);
      exp_oe = (sel && wen && !oen) ? ~bs : 2'b00;
      drive(c1n, c2, oen, wen, bs, AW'(i), d);
      if (!sel) begin
        chk("R2 deselect standby", {15'd0, standby}, 16'h0001);
        chk("R2 deselect oe", {14'd0, bus_oe}, 16'h0000);
      end else if (!wen) begin
        chk("R6 no drive in write", {14'd0, bus_oe}, 16'h0000);
        chk("R5 write standby low", {15'd0, standby}, 16'h0000);
      end else if (oen) begin
        chk("R3 output disable", {14'd0, bus_oe}, 16'h0000);
        chk("R3 standby low", {15'd0, standby}, 16'h0000);
      end else begin
        m = {{8{exp_oe[1]}}, {8{exp_oe[0]}}};
        chk("R4 lane enables", {14'd0, bus_oe}, {14'd0, exp_oe});
        chk("R4 lane data", bus_out & m, ref_mem[i] & m);
      end
      go_idle(AW'(i));
      if (sel && !wen) begin
        if (!bs[0]) ref_mem[i][7:0]  = d[7:0];
        if (!bs[1]) ref_mem[i][15:8] = d[15:8];
      end
    end

    // R7: data changed inside one overlap, last value kept
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, AW'(5), 16'hDEAD);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, AW'(5), 16'hBEEF);
    go_idle(AW'(5));
    ref_mem[5] = 16'hBEEF;
    read_word(AW'(5), "R7 last data in overlap");

    // R1/R5: every word read back, untouched lanes intact
    for (int a = 0; a < NW; a++) read_word(AW'(a), "R1 R5 readback");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule